// File: doc/BRIEF.md
# Debug-Port Flash Lock Checker

This block stands between a debug access port and an on-chip flash array and decides, request by request, whether a read, a byte write or an erase coming from the debugger may reach the array. The decision comes from two protection bytes stored in the flash itself. One byte governs reads and the other governs writes and erases. Each bit of a protection byte covers one 1 kB block of the first 8 kB of flash. A bit at 0 locks its block for that class of operation, and a bit at 1 leaves the block open.

After reset the block fetches both protection bytes through the same array read port that it later uses for debugger reads. Until both bytes are held, it keeps `req_ready` low and ignores requests. Once ready, an allowed request is passed to the array as a strobe in the same cycle. One cycle later a response reports allow or deny. For a denied read, the returned data is forced to zero.

Top module: `dbg_flash_guard`

## Requirements
- R1: Reset drives `req_ready` low. After reset is released, the block reads the read-lock byte at address 0x1DFF and then the write-lock byte at address 0x1DFE, with each byte returned on `arr_rdata` one cycle after its `arr_rd_en`. `req_ready` then rises within 12 cycles and stays high until the next reset.
- R2: While `req_ready` is low, a request with `req_valid` high raises none of `arr_wr_en` or `arr_erase_en` and produces no response.
- R3: The block index is address bits [15:10], so bit n of each lock byte governs addresses n*1024 to n*1024+1023.
- R4: A read (`req_op` = 2'b00) to a block whose read-lock bit is 0 is denied. `arr_rd_en` stays low, `resp_deny` is 1 and `rd_data` is 0 in the response cycle.
- R5: A read to a block whose read-lock bit is 1 is allowed. `arr_rd_en` is high in the request cycle, and the next cycle gives `resp_allow` = 1 with `rd_data` equal to the array byte at that address.
- R6: A write (`req_op` = 2'b01) raises `arr_wr_en` in the request cycle only if the block's write-lock bit is 1. Otherwise it is denied.
- R7: An erase (`req_op` = 2'b10) raises `arr_erase_en` in the request cycle only if the block's write-lock bit is 1. Otherwise it is denied.
- R8: The read decision depends only on the read-lock byte, and the write/erase decision depends only on the write-lock byte.
- R9: Addresses at 0x2000 and above are never locked, for any of the three operations.
- R10: Operation code 2'b11 is always denied and raises no array strobe.
- R11: Each accepted request produces `resp_valid` for exactly one cycle, the cycle after acceptance, with exactly one of `resp_allow` and `resp_deny` high. Without an accepted request, `resp_valid`, `resp_allow` and `resp_deny` are low and `rd_data` is 0.
- R12: During reset, `resp_valid`, `resp_allow`, `resp_deny`, `arr_wr_en` and `arr_erase_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Debugger request present |
| req_op | input | 2 | 00 read, 01 write, 10 erase, 11 reserved |
| req_addr | input | 16 | Byte address of the request |
| req_ready | output | 1 | Lock bytes loaded; requests are accepted |
| resp_valid | output | 1 | Response for the request accepted in the previous cycle |
| resp_allow | output | 1 | Request was allowed |
| resp_deny | output | 1 | Request was refused (one-cycle pulse) |
| rd_data | output | 8 | Read data, zero unless an allowed read |
| arr_rd_en | output | 1 | Array read strobe (loader or allowed read) |
| arr_wr_en | output | 1 | Array write strobe for an allowed write |
| arr_erase_en | output | 1 | Array erase strobe for an allowed erase |
| arr_addr | output | 16 | Array address |
| arr_rdata | input | 8 | Array read data, valid one cycle after `arr_rd_en` |

## Verification
The properties assume that the array returns data exactly one cycle after a read strobe and that `req_op` and `req_addr` are stable while `req_valid` is high. They also assume that requests arriving during the load phase are simply retried later. The stimulus stays within these assumptions. The bench's flash model answers every strobe on the next edge. Requests are driven on the falling edge and held for one full cycle, then dropped for one idle cycle. Random addresses cover the whole 64 kB space, so many of them land above the protected 8 kB. These random requests are mixed with directed hits on block edges, on the lock-byte addresses and on the reserved operation code, and the sequence is repeated under three lock patterns.

// File: rtl/flg_pkg.sv
package flg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } flg_op_e;

  typedef enum logic [1:0] {
    LD_RDLK  = 2'b00,
    LD_WELK  = 2'b01,
    LD_DONE  = 2'b10,
    LD_READY = 2'b11
  } flg_ld_e;

endpackage

// File: rtl/flg_rst_sync.sv
module flg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/flg_lock_loader.sv
module flg_lock_loader
  import flg_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          NUM_BLOCKS   = 8,
  parameter int unsigned RD_LOCK_ADDR = 32'h1DFF,
  parameter int unsigned WE_LOCK_ADDR = 32'h1DFE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     arr_rdata,
  output logic                  ld_rd_en,
  output logic [ADDR_W-1:0]     ld_addr,
  output logic [NUM_BLOCKS-1:0] rd_lock,
  output logic [NUM_BLOCKS-1:0] we_lock,
  output logic                  ready
);

  flg_ld_e state_q, state_d;
  logic    rd_cap_en, we_cap_en;

  // next-state and fetch control
  always_comb begin
    state_d   = state_q;
    ld_rd_en  = 1'b0;
    ld_addr   = ADDR_W'(RD_LOCK_ADDR);
    rd_cap_en = 1'b0;
    we_cap_en = 1'b0;
    unique case (state_q)
      LD_RDLK: begin
        ld_rd_en = 1'b1;
        ld_addr  = ADDR_W'(RD_LOCK_ADDR);
        state_d  = LD_WELK;
      end
      LD_WELK: begin
        ld_rd_en  = 1'b1;
        ld_addr   = ADDR_W'(WE_LOCK_ADDR);
        rd_cap_en = 1'b1;
        state_d   = LD_DONE;
      end
      LD_DONE: begin
        we_cap_en = 1'b1;
        state_d   = LD_READY;
      end
      default: begin
        state_d = LD_READY;
      end
    endcase
  end

  // registers; locks reset to all-locked until captured
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_RDLK;
      rd_lock <= '0;
      we_lock <= '0;
    end else begin
      state_q <= state_d;
      if (rd_cap_en) begin
        rd_lock <= arr_rdata[NUM_BLOCKS-1:0];
      end
      if (we_cap_en) begin
        we_lock <= arr_rdata[NUM_BLOCKS-1:0];
      end
    end
  end

  assign ready = (state_q == LD_READY);

endmodule

// File: rtl/flg_decide.sv
module flg_decide
  import flg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BLK_SHIFT  = 10,
  parameter int NUM_BLOCKS = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            op,
  input  logic [NUM_BLOCKS-1:0] rd_lock,
  input  logic [NUM_BLOCKS-1:0] we_lock,
  output logic                  allow
);

  localparam int IDX_W = ADDR_W - BLK_SHIFT;

  logic [IDX_W-1:0]      blk_idx;
  logic [NUM_BLOCKS-1:0] blk_hit;
  logic                  rd_open, we_open;

  assign blk_idx = addr[ADDR_W-1:BLK_SHIFT];

  // one-hot block decode; an index past the last block hits nothing
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_hit
    assign blk_hit[b] = (blk_idx == IDX_W'(b));
  end

  assign rd_open = ~|(blk_hit & ~rd_lock);
  assign we_open = ~|(blk_hit & ~we_lock);

  always_comb begin
    unique case (op)
      OP_READ:  allow = rd_open;
      OP_WRITE: allow = we_open;
      OP_ERASE: allow = we_open;
      default:  allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/flg_resp.sv
module flg_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              allow,
  input  logic              is_read,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              resp_deny,
  output logic [DATA_W-1:0] rd_data
);

  logic valid_q, allow_q, pass_q;
  logic valid_d, allow_d, pass_d;

  always_comb begin
    valid_d = fire;
    allow_d = fire & allow;
    pass_d  = fire & allow & is_read;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      allow_q <= allow_d;
      pass_q  <= pass_d;
    end
  end

  assign resp_valid = valid_q;
  assign resp_allow = allow_q;
  assign resp_deny  = valid_q & ~allow_q;
  assign rd_data    = pass_q ? arr_rdata : '0;

endmodule

// File: rtl/dbg_flash_guard.sv
module dbg_flash_guard
  import flg_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 8,
  parameter int          BLK_SHIFT    = 10,
  parameter int          NUM_BLOCKS   = 8,
  parameter int unsigned RD_LOCK_ADDR = 32'h1DFF,
  parameter int unsigned WE_LOCK_ADDR = 32'h1DFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              resp_deny,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_rd_en,
  output logic              arr_wr_en,
  output logic              arr_erase_en,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata
);

  logic                  rst_s_n;
  logic                  ld_rd_en;
  logic [ADDR_W-1:0]     ld_addr;
  logic [NUM_BLOCKS-1:0] rd_lock, we_lock;
  logic                  ready, allow, fire;

  flg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  flg_lock_loader #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .NUM_BLOCKS   (NUM_BLOCKS),
    .RD_LOCK_ADDR (RD_LOCK_ADDR),
    .WE_LOCK_ADDR (WE_LOCK_ADDR)
  ) u_load (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .arr_rdata (arr_rdata),
    .ld_rd_en  (ld_rd_en),
    .ld_addr   (ld_addr),
    .rd_lock   (rd_lock),
    .we_lock   (we_lock),
    .ready     (ready)
  );

  flg_decide #(
    .ADDR_W     (ADDR_W),
    .BLK_SHIFT  (BLK_SHIFT),
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_dec (
    .addr    (req_addr),
    .op      (req_op),
    .rd_lock (rd_lock),
    .we_lock (we_lock),
    .allow   (allow)
  );

  assign fire = req_valid & ready;

  flg_resp #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fire       (fire),
    .allow      (allow),
    .is_read    (req_op == OP_READ),
    .arr_rdata  (arr_rdata),
    .resp_valid (resp_valid),
    .resp_allow (resp_allow),
    .resp_deny  (resp_deny),
    .rd_data    (rd_data)
  );

  assign req_ready    = ready;
  assign arr_rd_en    = ready ? (fire & allow & (req_op == OP_READ)) : ld_rd_en;
  assign arr_wr_en    = fire & allow & (req_op == OP_WRITE);
  assign arr_erase_en = fire & allow & (req_op == OP_ERASE);
  assign arr_addr     = ready ? req_addr : ld_addr;

endmodule

// File: rtl/flg_chk.sv
module flg_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BLK_SHIFT  = 10,
  parameter int NUM_BLOCKS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_allow,
  input logic              resp_deny,
  input logic [DATA_W-1:0] rd_data,
  input logic              arr_rd_en,
  input logic              arr_wr_en,
  input logic              arr_erase_en,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_rdata
);

  localparam int IDX_W = ADDR_W - BLK_SHIFT;

  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  // R2
  no_strobe_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!arr_wr_en && !arr_erase_en));

  // R4
  masked_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_allow |-> (rd_data == '0));

  // R9
  high_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op != 2'b11 &&
     req_addr[ADDR_W-1:BLK_SHIFT] >= IDX_W'(NUM_BLOCKS)) |=> resp_allow);

  // R10
  rsvd_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |->
      (!arr_rd_en && !arr_wr_en && !arr_erase_en));

  // R11
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_allow ^ resp_deny));

  // R11
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $onehot0({arr_rd_en, arr_wr_en, arr_erase_en}));

endmodule

bind dbg_flash_guard flg_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BLK_SHIFT  (BLK_SHIFT),
  .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (.*);

// File: tb/dbg_flash_guard_test.sv
`timescale 1ns/1ps
module dbg_flash_guard_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [15:0] req_addr;
  logic        req_ready, resp_valid, resp_allow, resp_deny;
  logic [7:0]  rd_data;
  logic        arr_rd_en, arr_wr_en, arr_erase_en;
  logic [15:0] arr_addr;
  logic [7:0]  arr_rdata;

  logic [7:0]  rd_v, we_v;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  dbg_flash_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_allow(resp_allow), .resp_deny(resp_deny), .rd_data(rd_data),
    .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en), .arr_erase_en(arr_erase_en),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    if (a == 16'h1DFF) return rd_v;
    if (a == 16'h1DFE) return we_v;
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // flash model: one-cycle read latency
  always @(posedge clk) begin
    if (arr_rd_en) arr_rdata <= mem_val(arr_addr);
  end

  function automatic bit exp_allow(input logic [1:0] op, input logic [15:0] a);
    int  idx = int'(a[15:10]);
    bit  rd_ok = (idx < 8) ? rd_v[idx] : 1'b1;
    bit  we_ok = (idx < 8) ? we_v[idx] : 1'b1;
    case (op)
      2'b00:   return rd_ok;
      2'b01:   return we_ok;
      2'b10:   return we_ok;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] rv, input logic [7:0] wv);
    rd_v = rv;
    we_v = wv;
    req_valid = 1'b0;
    req_op = 2'b00;
    req_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!resp_valid && !resp_allow && !resp_deny && !arr_wr_en && !arr_erase_en,
        "R12 outputs in reset", {resp_valid, resp_allow, resp_deny, arr_wr_en, arr_erase_en}, 0);
    chk(!req_ready, "R1 ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    // R2: request during load is ignored
    req_valid = 1'b1;
    req_op = 2'b01;
    req_addr = 16'h2000;
    @(negedge clk);
    chk(!req_ready, "R1 ready low after release", req_ready, 0);
    chk(!arr_wr_en, "R2 no write strobe while loading", arr_wr_en, 0);
    @(negedge clk);
    chk(!resp_valid, "R2 no response while loading", resp_valid, 0);
    req_valid = 1'b0;
    for (int i = 0; i < 12 && !req_ready; i++) @(negedge clk);
    chk(req_ready, "R1 ready after lock load", req_ready, 1);
  endtask

  task automatic do_req(input logic [1:0] op, input logic [15:0] a, input string rq);
    bit          e;
    logic [7:0]  ed;
    @(negedge clk);
    chk(!resp_valid && !resp_deny && rd_data == 0, {rq, " R11 idle before request"},
        {resp_valid, resp_deny, rd_data}, 0);
    e = exp_allow(op, a);
    req_valid = 1'b1;
    req_op = op;
    req_addr = a;
    #1;
    chk(arr_rd_en == (op == 2'b00 && e) && arr_wr_en == (op == 2'b01 && e) &&
        arr_erase_en == (op == 2'b10 && e), {rq, " strobes"},
        {arr_rd_en, arr_wr_en, arr_erase_en},
        {(op == 2'b00 && e), (op == 2'b01 && e), (op == 2'b10 && e)});
    @(negedge clk);
    req_valid = 1'b0;
    ed = (op == 2'b00 && e) ? mem_val(a) : 8'h00;
    chk(resp_valid && resp_allow == e && resp_deny == !e, {rq, " R11 response"},
        {resp_valid, resp_allow, resp_deny}, {1'b1, e, !e});
    chk(rd_data == ed, {rq, " read data"}, rd_data, ed);
    chk(req_ready, "R1 ready stays high", req_ready, 1);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0]  op = 2'($urandom_range(0, 3));
      logic [15:0] a  = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 16'h1FFF))
                                                     : 16'($urandom);
      do_req(op, a, "R3 R8 random");
    end
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    // pattern A: read lock 1010_0101, write lock 0011_1100
    start(8'hA5, 8'h3C);
    do_req(2'b00, 16'h03FF, "R3 R5 last byte of open block 0");
    do_req(2'b00, 16'h0400, "R3 R4 first byte of locked block 1");
    do_req(2'b01, 16'h0800, "R6 write open block 2");
    do_req(2'b01, 16'h0400, "R6 write locked block 1");
    do_req(2'b10, 16'h1400, "R7 erase open block 5");
    do_req(2'b10, 16'h1C00, "R7 erase locked block 7");
    do_req(2'b01, 16'h0000, "R8 block 0 write locked while read open");
    do_req(2'b00, 16'h0C00, "R8 block 3 read locked");
    do_req(2'b01, 16'h0C00, "R8 block 3 write open");
    do_req(2'b00, 16'h2000, "R9 read above 8 kB");
    do_req(2'b01, 16'h2000, "R9 write above 8 kB");
    do_req(2'b10, 16'hFFFF, "R9 erase top address");
    do_req(2'b11, 16'h0000, "R10 reserved op");
    do_req(2'b00, 16'h1DFF, "R5 read of lock byte");
    random_run(200);
    // pattern B: everything locked
    start(8'h00, 8'h00);
    do_req(2'b00, 16'h1FFF, "R4 all locked read");
    do_req(2'b10, 16'h0000, "R7 all locked erase");
    do_req(2'b00, 16'h4321, "R9 all locked high read");
    random_run(200);
    // pattern C: everything open
    start(8'hFF, 8'hFF);
    do_req(2'b01, 16'h1DFE, "R6 all open write");
    do_req(2'b11, 16'h2400, "R10 reserved high");
    random_run(200);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule